// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit base-address register that places the memory-mapped PCIe configuration window. From that register it derives three values: whether the window is on, where it starts, and how long it is. It also produces the bounds of the 32-bit PCI memory hole. The hole opens at the end of the window and closes one byte below the default I/O APIC address.

Software writes the register through a word-wide port. A word index and per-byte lane enables pick the bytes to change. A combinational read port returns the stored value unchanged.

The length field has a reserved code. A write that leaves that code in the register does not disturb the decode. The outputs keep the last valid decode and a sticky error flag is set.

Top module: `cfgwin_decoder`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00000000_B0000000. The window is disabled, the length code is 256 MB, the base is 0xB0000000 and the error flag is clear.
- R2: Register bit 0 is the window enable. Bits 2:1 hold the length code: 00 gives `win_len` = 0x10000000, 01 gives 0x08000000 and 10 gives 0x04000000.
- R3: `win_base` copies register bits 35:28 for the 256 MB code, bits 35:27 for the 128 MB code and bits 35:26 for the 64 MB code. All other bits of `win_base` are zero, so register bits above 35 are ignored.
- R4: While the window is enabled, `hole_start` equals `win_base + win_len`, taken modulo 2^36.
- R5: While the window is disabled, `hole_start` is 0xB0000000. `hole_end` is always 0xFEBFFFFF.
- R6: On a write, lane k of word w updates register byte 4*w+k, and only when `wr_be[k]` is set. A write with no lane set has no effect. `rd_data` returns word `rd_word` of the raw register.
- R7: A write that leaves length code 11 in the register sets `len_err`. The decoded outputs keep their previous values, while the raw register still reads back the written bytes.
- R8: `len_err` stays set until reset. A later write that leaves a valid code decodes normally.
- R9: The decoded outputs show a write in the cycle that follows the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | Index of the register word to write |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_word | input | 1 | Index of the register word to read |
| rd_data | output | 32 | Raw register word |
| win_en | output | 1 | Configuration window enabled |
| win_base | output | 36 | Decoded window base address |
| win_len | output | 36 | Window length in bytes |
| hole_start | output | 36 | First byte of the PCI memory hole |
| hole_end | output | 32 | Last byte of the PCI memory hole |
| len_err | output | 1 | Sticky flag for a reserved length code |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 36-bit address and a 64 MB smallest window. The narrow data word splits the register into two words. This lets partial writes reach the base bits above bit 31 and the bits above the address range, which must be ignored. It also covers the case where a write to the upper word leaves a reserved code that an earlier write put in the lower word.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the configuration window decoder.
// Assumes the enable bit and the two-bit length code sit at the bottom of the register.
package cfgwin_pkg;

    // Bit position of the window enable
    localparam int EN_BIT  = 0;
    // Lowest bit of the two-bit length code
    localparam int LEN_LSB = 1;

    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } len_code_e;

    // True when the length code is the reserved value
    function automatic logic code_is_reserved(input logic [1:0] code);
        return code == LEN_RSVD;
    endfunction

endpackage

// File: rtl/cfgwin_regfile.sv
`timescale 1ns/1ps
// Module: byte-lane register store for the window register.
// Keeps REG_W bits split into DW-bit words. Each write changes the enabled lanes of one word.
// Also presents the value the register takes at the next edge.
// Assumes REG_W is a multiple of DW and DW is a multiple of 8.
module cfgwin_regfile #(
    parameter int               REG_W     = 64,
    parameter int               DW        = 32,
    parameter logic [REG_W-1:0] RESET_VAL = '0,
    parameter int               WSEL_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DW/8-1:0]   wr_be,
    input  logic [DW-1:0]     wr_data,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DW-1:0]     rd_data,
    output logic [REG_W-1:0]  reg_d,
    output logic              wr_hit
);
    localparam int NWORDS = REG_W / DW;
    localparam int BPW    = DW / 8;
    localparam int NBYTES = REG_W / 8;

    logic [REG_W-1:0] reg_q;

    // A write counts only when it names an existing word and enables at least one lane
    assign wr_hit = wr_en && (|wr_be) && (32'(wr_word) < NWORDS);

    // Next value, built one byte at a time
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int WIDX = b / BPW;
        localparam int LANE = b % BPW;
        assign reg_d[b*8 +: 8] =
            (wr_hit && (32'(wr_word) == WIDX) && wr_be[LANE])
                ? wr_data[LANE*8 +: 8] : reg_q[b*8 +: 8];
    end

    // Storage: load the reset value, otherwise take the next value
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= RESET_VAL;
        else        reg_q <= reg_d;
    end

    // Read port: raw word selected by rd_word
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (32'(rd_word) == w) rd_data = reg_q[w*DW +: DW];
        end
    end
endmodule

// File: rtl/cfgwin_decode.sv
`timescale 1ns/1ps
// Module: turns a stored register image into enable, base and length.
// The two length bits widen the base mask toward MIN_SHIFT.
// Assumes the image never holds the reserved code; the top filters that case out.
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W    = 36,
    parameter int MIN_SHIFT = 26
) (
    input  logic [ADDR_W-1:0] cfg,
    output logic              en,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] len
);
    localparam logic [ADDR_W-1:0] LEN_BIG = ADDR_W'(1) << (MIN_SHIFT + 2);
    localparam logic [ADDR_W-1:0] LEN_MID = ADDR_W'(1) << (MIN_SHIFT + 1);
    localparam logic [ADDR_W-1:0] LEN_SML = ADDR_W'(1) << MIN_SHIFT;

    len_code_e         code;
    logic [ADDR_W-1:0] mask;

    assign code = len_code_e'(cfg[LEN_LSB +: 2]);
    assign en   = cfg[EN_BIT];

    // Length and mask: smaller windows reveal lower base bits
    always_comb begin
        mask = '0;
        mask[ADDR_W-1:MIN_SHIFT+2] = '1;
        len  = LEN_BIG;
        case (code)
            LEN_128M: begin
                mask[MIN_SHIFT+1] = 1'b1;
                len = LEN_MID;
            end
            LEN_64M: begin
                mask[MIN_SHIFT+1] = 1'b1;
                mask[MIN_SHIFT]   = 1'b1;
                len = LEN_SML;
            end
            default: len = LEN_BIG;
        endcase
    end

    // Base: register bits kept by the mask
    assign base = cfg & mask;
endmodule

// File: rtl/cfgwin_hole.sv
`timescale 1ns/1ps
// Module: bounds of the 32-bit PCI memory hole.
// The hole starts right after an enabled window, or at the default base when the window is off.
// It always ends one byte below the I/O APIC address.
module cfgwin_hole #(
    parameter int                ADDR_W    = 36,
    parameter logic [ADDR_W-1:0] DEF_BASE  = 36'hB000_0000,
    parameter logic [31:0]       APIC_BASE = 32'hFEC0_0000
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] start,
    output logic [31:0]       last
);
    localparam logic [31:0] HOLE_LAST = APIC_BASE - 32'd1;

    // Start of the hole follows the window end only while the window is on
    always_comb begin
        if (en) start = base + len;
        else    start = DEF_BASE;
    end

    assign last = HOLE_LAST;
endmodule

// File: rtl/cfgwin_decoder.sv
`timescale 1ns/1ps
// Module: top of the configuration window decoder.
// Keeps the raw register, plus a shadow holding the last image with a valid length code.
// The outputs are decoded from that shadow, so a reserved code leaves them unchanged and sets a sticky flag.
// Assumes a synchronous active-low reset. Outputs follow registered state with no further delay.
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int               REG_W     = 64,
    parameter int               DW        = 32,
    parameter int               ADDR_W    = 36,
    parameter int               MIN_SHIFT = 26,
    parameter logic [REG_W-1:0] DEF_BASE  = 64'h0000_0000_B000_0000,
    parameter logic [31:0]      APIC_BASE = 32'hFEC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [0:0]        wr_word,
    input  logic [DW/8-1:0]   wr_be,
    input  logic [DW-1:0]     wr_data,
    input  logic [0:0]        rd_word,
    output logic [DW-1:0]     rd_data,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] win_len,
    output logic [ADDR_W-1:0] hole_start,
    output logic [31:0]       hole_end,
    output logic              len_err
);
    localparam int BPW = DW / 8;

    logic [REG_W-1:0]  reg_d;
    logic              wr_hit;
    logic              rsvd_d;
    logic [ADDR_W-1:0] shadow_q;
    logic              err_q;

    cfgwin_regfile #(
        .REG_W(REG_W), .DW(DW), .RESET_VAL(DEF_BASE), .WSEL_W(1)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_be(wr_be), .wr_data(wr_data), .rd_word(rd_word),
        .rd_data(rd_data), .reg_d(reg_d), .wr_hit(wr_hit)
    );

    // Reserved-code test on the value the register is about to take
    assign rsvd_d = code_is_reserved(reg_d[LEN_LSB +: 2]);

    // Shadow and error flag: refresh on any touching write, refuse reserved images
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= DEF_BASE[ADDR_W-1:0];
            err_q    <= 1'b0;
        end else if (wr_hit) begin
            if (rsvd_d) err_q    <= 1'b1;
            else        shadow_q <= reg_d[ADDR_W-1:0];
        end
    end

    // Register bits above the address range play no part in decoding
    logic unused_hi;
    assign unused_hi = ^reg_d[REG_W-1:ADDR_W];

    cfgwin_decode #(
        .ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT)
    ) u_dec (
        .cfg(shadow_q), .en(win_en), .base(win_base), .len(win_len)
    );

    cfgwin_hole #(
        .ADDR_W(ADDR_W), .DEF_BASE(DEF_BASE[ADDR_W-1:0]), .APIC_BASE(APIC_BASE)
    ) u_hole (
        .en(win_en), .base(win_base), .len(win_len),
        .start(hole_start), .last(hole_end)
    );

    assign len_err = err_q;
endmodule

// File: rtl/cfgwin_decoder_chk.sv
`timescale 1ns/1ps
// Module: property checker for cfgwin_decoder, bound to every instance.
// Observes ports only.
module cfgwin_decoder_chk #(
    parameter int                ADDR_W    = 36,
    parameter int                BPW       = 4,
    parameter int                MIN_SHIFT = 26,
    parameter logic [ADDR_W-1:0] DEF_BASE  = 36'hB000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [BPW-1:0]    wr_be,
    input logic              win_en,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_len,
    input logic [ADDR_W-1:0] hole_start,
    input logic              len_err
);
    // R2
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len == (ADDR_W'(1) << MIN_SHIFT)) ||
        (win_len == (ADDR_W'(1) << (MIN_SHIFT + 1))) ||
        (win_len == (ADDR_W'(1) << (MIN_SHIFT + 2))));

    // R3
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base & (win_len - ADDR_W'(1))) == '0);

    // R4
    hole_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> (hole_start == ADDR_W'(win_base + win_len)));

    // R5
    hole_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> (hole_start == DEF_BASE));

    // R6
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|wr_be)) |=> ($stable(win_base) && $stable(win_len) && $stable(win_en)));

    // R7
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> ($stable(win_base) && $stable(win_len) && $stable(win_en)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);
endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(
    .ADDR_W(ADDR_W), .BPW(BPW), .MIN_SHIFT(MIN_SHIFT), .DEF_BASE(DEF_BASE[ADDR_W-1:0])
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .win_en(win_en),
    .win_base(win_base), .win_len(win_len), .hole_start(hole_start), .len_err(len_err)
);

// File: tb/cfgwin_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_decoder_test;
    localparam int ADDR_W = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_word = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [0:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        win_en;
    logic [ADDR_W-1:0] win_base, win_len, hole_start;
    logic [31:0] hole_end;
    logic        len_err;

    always #5 clk = ~clk;

    cfgwin_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_be(wr_be),
        .wr_data(wr_data), .rd_word(rd_word), .rd_data(rd_data), .win_en(win_en),
        .win_base(win_base), .win_len(win_len), .hole_start(hole_start),
        .hole_end(hole_end), .len_err(len_err)
    );

    typedef struct {
        string             tag;
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W-1:0] hs;
        logic              err;
        logic [31:0]       rdd;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Reference state built from the requirements
    logic [63:0] m_reg;
    logic [63:0] m_shadow;
    logic        m_err;

    task automatic push_exp(input string tag);
        exp_t e;
        logic [1:0] code;
        code = m_shadow[2:1];
        e.tag = tag;
        e.en  = m_shadow[0];
        e.len = (code == 2'b00) ? 36'h010000000 : (code == 2'b01) ? 36'h008000000 : 36'h004000000;
        e.base = m_shadow[ADDR_W-1:0] & ~(e.len - 36'd1);
        e.hs  = e.en ? ADDR_W'(e.base + e.len) : 36'h0B0000000;
        e.err = m_err;
        e.rdd = m_reg[rd_word*32 +: 32];
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expectation per cycle and compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            cur = q.pop_front();
            cmp(cur.tag, "win_en",     64'(win_en),     64'(cur.en));
            cmp(cur.tag, "win_base",   64'(win_base),   64'(cur.base));
            cmp(cur.tag, "win_len",    64'(win_len),    64'(cur.len));
            cmp(cur.tag, "hole_start", 64'(hole_start), 64'(cur.hs));
            cmp(cur.tag, "hole_end",   64'(hole_end),   64'h0FEBFFFFF);
            cmp(cur.tag, "len_err",    64'(len_err),    64'(cur.err));
            cmp(cur.tag, "rd_data",    64'(rd_data),    64'(cur.rdd));
        end
    end

    task automatic model_reset();
        m_reg = 64'h0000_0000_B000_0000;
        m_shadow = m_reg;
        m_err = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        model_reset();
        push_exp(tag);
    endtask

    task automatic do_write(input logic w, input logic [3:0] be, input logic [31:0] d,
                            input logic rw, input string tag);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_word = w; wr_be = be; wr_data = d; rd_word = rw;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_be = '0;
        for (int b = 0; b < 4; b++)
            if (be[b]) m_reg[w*32 + b*8 +: 8] = d[b*8 +: 8];
        if (be != 4'b0) begin
            if (m_reg[2:1] == 2'b11) m_err = 1'b1;
            else                     m_shadow = m_reg;
        end
        push_exp(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_exp("R1 reset state");
        do_write(1'b0, 4'hF, 32'hE000_0001, 1'b0, "R2 R4 R9 256MB enabled");
        do_write(1'b0, 4'hF, 32'hE800_0003, 1'b0, "R2 R3 128MB enabled");
        do_write(1'b0, 4'hF, 32'hEC00_0005, 1'b0, "R2 R3 64MB enabled");
        do_write(1'b0, 4'hF, 32'hEC00_0001, 1'b0, "R3 256MB masks bits 27:26");
        do_write(1'b0, 4'hF, 32'hEC00_0003, 1'b0, "R3 128MB masks bit 26");
        do_write(1'b0, 4'hF, 32'hEC00_0004, 1'b0, "R5 disabled hole at default");
        do_write(1'b0, 4'h1, 32'h5555_5501, 1'b0, "R6 single lane write");
        do_write(1'b0, 4'h0, 32'h1234_5677, 1'b0, "R6 no lane write ignored");
        do_write(1'b1, 4'hF, 32'hFFFF_FF0F, 1'b1, "R3 R4 upper base bits");
        do_write(1'b0, 4'hF, 32'hEC00_0007, 1'b0, "R7 reserved code holds decode");
        do_write(1'b1, 4'h1, 32'h0000_0000, 1'b1, "R7 upper write keeps reserved");
        do_write(1'b0, 4'hF, 32'hE800_0003, 1'b0, "R8 sticky error valid decode");
        do_reset("R1 R8 reset clears error");
        do_write(1'b0, 4'hF, 32'hD800_0002, 1'b0, "R5 128MB disabled");
        do_write(1'b0, 4'h2, 32'h0000_0000, 1'b0, "R6 lane 1 write");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule